// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block turns a 64-bit virtual address into a 48-bit physical address for a 64KB-granule, 42-bit address space. The walk uses descriptors fetched one at a time over a simple memory read port. The upper address field picks one of two table base addresses. The walk then reads one level-2 descriptor. A block descriptor there finishes the walk with a 512MB mapping. A table descriptor leads to one more read, at level 3, which maps a 64KB page.

A requester presents an address and a write flag while the walker is idle. Some time later the walker raises a one-cycle result pulse. The pulse carries either the physical address and the attribute bits of the final descriptor, or a fault kind and the level at which the fault was found. With tag mode on, the top address byte is ignored. The walker checks address canonicity, descriptor validity, descriptor type, and write permission.

Top module: `ttw_walker`

## Requirements
- R1: An address whose field above bit 41 is neither all zeros nor all ones ends with `done_fault`=1 (address fault) and `done_level`=0. The result pulse comes in the cycle after acceptance and no memory read is issued.
- R2: An all-ones upper field uses `base_hi` as the level-2 table base. An all-zeros upper field uses `base_lo`.
- R3: When `tag_en` is 1, bits [63:56] are ignored. Only bits [55:42] are checked for canonicity, and bit 55 picks the base.
- R4: The level-2 read address is the selected base plus VA[41:29] times 8.
- R5: A valid level-2 descriptor with bit 1 clear (block) returns `done_fault`=0, `done_level`=2 and PA = {desc[47:29], VA[28:0]}.
- R6: A valid level-2 descriptor with bit 1 set (table) issues a level-3 read at {desc[47:16], 16'h0} plus VA[28:16] times 8.
- R7: A valid level-3 descriptor with bit 1 set (page) returns `done_fault`=0, `done_level`=3 and PA = {desc[47:16], VA[15:0]}.
- R8: A descriptor with bit 0 clear, or a level-3 descriptor with bit 1 clear, ends with `done_fault`=2 (translation fault) and `done_level` set to the level of that descriptor.
- R9: A write request that meets a descriptor with bit 7 set ends with `done_fault`=3 (permission fault) at that descriptor's level. A read request passes such a descriptor unaffected.
- R10: A memory request holds `mem_req_valid` and a stable address until `mem_req_ready`. Only one read is outstanding at a time. `done` is a one-cycle pulse in the cycle after the response that ends the walk.
- R11: `req_ready` is high only while idle. A request presented while busy is ignored.
- R12: On success, `done_attr` = {desc[63:48], desc[15:2]} of the final descriptor. On a fault, `done_pa` and `done_attr` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request taken this cycle |
| req_va | input | 64 | Virtual address |
| req_write | input | 1 | 1 = write access, 0 = read |
| tag_en | input | 1 | Ignore top address byte |
| base_lo | input | 48 | Level-2 table base for the lower region |
| base_hi | input | 48 | Level-2 table base for the upper region |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 48 | Descriptor byte address |
| mem_rsp_valid | input | 1 | Descriptor data returned |
| mem_rsp_data | input | 64 | Descriptor |
| done | output | 1 | One-cycle result pulse |
| done_fault | output | 2 | 0 none, 1 address, 2 translation, 3 permission |
| done_level | output | 2 | Level of final descriptor or fault (0 for address fault) |
| done_pa | output | 48 | Physical address |
| done_attr | output | 30 | Attribute bits of the final descriptor |

## Verification
The result pulse of one translation can fall in the same cycle as the acceptance of the next request, because the walker is idle again while `done` is high. The bench provokes this by holding `req_valid` high across a non-canonical address and then switching to a canonical one. It expects the address fault pulse with `req_ready` high in one cycle. In the following cycle it expects no pulse and a level-2 read at the address computed for the second request.

// File: rtl/ttw_pkg.sv
package ttw_pkg;
  localparam int VA_W    = 64;
  localparam int SPACE_W = 42;
  localparam int PA_W    = 48;
  localparam int TAG_W   = 8;
  localparam int PG_SH   = 16;
  localparam int IDX_W   = 13;
  localparam int DESC_W  = 64;
  localparam int RO_BIT  = 7;
  localparam int ENT_SH  = 3;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_ADDR = 2'd1,
    FLT_XLAT = 2'd2,
    FLT_PERM = 2'd3
  } fault_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RD2  = 3'd1,
    ST_WT2  = 3'd2,
    ST_RD3  = 3'd3,
    ST_WT3  = 3'd4
  } state_e;
endpackage

// File: rtl/ttw_va_check.sv
module ttw_va_check #(
  parameter int VA_W    = 64,
  parameter int SPACE_W = 42,
  parameter int TAG_W   = 8
) (
  input  logic [VA_W-SPACE_W-1:0] upper,
  input  logic                    tag_en,
  output logic                    canon_ok,
  output logic                    sel_hi
);
  localparam int UP_W  = VA_W - SPACE_W;
  localparam int UT_W  = UP_W - TAG_W;

  logic full_ok;
  assign full_ok = (&upper) | ~(|upper);

  generate
    if (TAG_W > 0) begin : g_tag
      logic [UT_W-1:0] low_part;
      logic            low_ok;
      assign low_part = upper[UT_W-1:0];
      assign low_ok   = (&low_part) | ~(|low_part);
      assign canon_ok = tag_en ? low_ok : full_ok;
      assign sel_hi   = tag_en ? low_part[UT_W-1] : upper[UP_W-1];
    end else begin : g_plain
      logic unused_tag;
      assign unused_tag = tag_en;
      assign canon_ok   = full_ok;
      assign sel_hi     = upper[UP_W-1];
    end
  endgenerate
endmodule

// File: rtl/ttw_desc_decode.sv
module ttw_desc_decode
  import ttw_pkg::*;
#(
  parameter int DESC_W = 64,
  parameter int PA_W   = 48,
  parameter int PG_SH  = 16,
  parameter int RO_BIT = 7
) (
  input  logic [DESC_W-1:0]                desc,
  input  logic                             last_lvl,
  input  logic                             write,
  output fault_e                           fault,
  output logic                             go_next,
  output logic [PA_W-1:0]                  base_out,
  output logic [(DESC_W-PA_W)+PG_SH-3:0]   attr
);
  logic is_valid, type_bit, read_only;

  assign is_valid  = desc[0];
  assign type_bit  = desc[1];
  assign read_only = desc[RO_BIT];

  always_comb begin
    if (!is_valid)                  fault = FLT_XLAT;
    else if (last_lvl && !type_bit) fault = FLT_XLAT;
    else if (write && read_only)    fault = FLT_PERM;
    else                            fault = FLT_NONE;
  end

  assign go_next  = !last_lvl && type_bit && (fault == FLT_NONE);
  assign base_out = {desc[PA_W-1:PG_SH], {PG_SH{1'b0}}};
  assign attr     = {desc[DESC_W-1:PA_W], desc[PG_SH-1:2]};
endmodule

// File: rtl/ttw_walker.sv
module ttw_walker
  import ttw_pkg::*;
#(
  parameter int VA_W    = ttw_pkg::VA_W,
  parameter int SPACE_W = ttw_pkg::SPACE_W,
  parameter int PA_W    = ttw_pkg::PA_W,
  parameter int TAG_W   = ttw_pkg::TAG_W,
  parameter int PG_SH   = ttw_pkg::PG_SH,
  parameter int IDX_W   = ttw_pkg::IDX_W,
  parameter int DESC_W  = ttw_pkg::DESC_W,
  parameter int RO_BIT  = ttw_pkg::RO_BIT,
  parameter int ENT_SH  = ttw_pkg::ENT_SH
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           req_valid,
  output logic                           req_ready,
  input  logic [VA_W-1:0]                req_va,
  input  logic                           req_write,
  input  logic                           tag_en,
  input  logic [PA_W-1:0]                base_lo,
  input  logic [PA_W-1:0]                base_hi,
  output logic                           mem_req_valid,
  input  logic                           mem_req_ready,
  output logic [PA_W-1:0]                mem_req_addr,
  input  logic                           mem_rsp_valid,
  input  logic [DESC_W-1:0]              mem_rsp_data,
  output logic                           done,
  output logic [1:0]                     done_fault,
  output logic [1:0]                     done_level,
  output logic [PA_W-1:0]                done_pa,
  output logic [(DESC_W-PA_W)+PG_SH-3:0] done_attr
);
  localparam int BLK_SH = PG_SH + IDX_W;
  localparam int ATTR_W = (DESC_W - PA_W) + PG_SH - 2;

  state_e              state_q, state_d;
  logic [BLK_SH-1:0]   off_q;
  logic                wr_q;
  logic [PA_W-1:0]     addr_q, addr_d;
  logic                addr_ld, acc;
  logic                done_q, done_d;
  fault_e              code_q, code_d;
  logic [1:0]          lvl_q, lvl_d;
  logic [PA_W-1:0]     pa_q, pa_d;
  logic [ATTR_W-1:0]   attr_q, attr_d;

  logic                canon_ok, sel_hi, at_l3, dec_next;
  fault_e              dec_fault;
  logic [PA_W-1:0]     dec_base, l2_off, l3_off;
  logic [ATTR_W-1:0]   dec_attr;

  ttw_va_check #(.VA_W(VA_W), .SPACE_W(SPACE_W), .TAG_W(TAG_W)) va_chk_i (
    .upper    (req_va[VA_W-1:SPACE_W]),
    .tag_en   (tag_en),
    .canon_ok (canon_ok),
    .sel_hi   (sel_hi)
  );

  ttw_desc_decode #(.DESC_W(DESC_W), .PA_W(PA_W), .PG_SH(PG_SH), .RO_BIT(RO_BIT)) dec_i (
    .desc     (mem_rsp_data),
    .last_lvl (at_l3),
    .write    (wr_q),
    .fault    (dec_fault),
    .go_next  (dec_next),
    .base_out (dec_base),
    .attr     (dec_attr)
  );

  assign req_ready     = (state_q == ST_IDLE);
  assign acc           = req_valid && req_ready;
  assign mem_req_valid = (state_q == ST_RD2) || (state_q == ST_RD3);
  assign mem_req_addr  = addr_q;
  assign at_l3         = (state_q == ST_WT3);
  assign l2_off        = PA_W'({req_va[BLK_SH+IDX_W-1:BLK_SH], {ENT_SH{1'b0}}});
  assign l3_off        = PA_W'({off_q[BLK_SH-1:PG_SH], {ENT_SH{1'b0}}});

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    addr_ld = 1'b0;
    done_d  = 1'b0;
    code_d  = code_q;
    lvl_d   = lvl_q;
    pa_d    = pa_q;
    attr_d  = attr_q;
    case (state_q)
      ST_IDLE: begin
        if (acc) begin
          if (!canon_ok) begin
            done_d = 1'b1;
            code_d = FLT_ADDR;
            lvl_d  = 2'd0;
            pa_d   = '0;
            attr_d = '0;
          end else begin
            addr_d  = (sel_hi ? base_hi : base_lo) + l2_off;
            addr_ld = 1'b1;
            state_d = ST_RD2;
          end
        end
      end
      ST_RD2: if (mem_req_ready) state_d = ST_WT2;
      ST_RD3: if (mem_req_ready) state_d = ST_WT3;
      ST_WT2, ST_WT3: begin
        if (mem_rsp_valid) begin
          lvl_d = at_l3 ? 2'd3 : 2'd2;
          if (dec_fault != FLT_NONE) begin
            done_d  = 1'b1;
            code_d  = dec_fault;
            pa_d    = '0;
            attr_d  = '0;
            state_d = ST_IDLE;
          end else if (dec_next) begin
            addr_d  = dec_base + l3_off;
            addr_ld = 1'b1;
            state_d = ST_RD3;
          end else begin
            done_d  = 1'b1;
            code_d  = FLT_NONE;
            pa_d    = at_l3 ? {dec_base[PA_W-1:PG_SH], off_q[PG_SH-1:0]}
                            : {dec_base[PA_W-1:BLK_SH], off_q[BLK_SH-1:0]};
            attr_d  = dec_attr;
            state_d = ST_IDLE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      off_q   <= '0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      done_q  <= 1'b0;
      code_q  <= FLT_NONE;
      lvl_q   <= 2'd0;
      pa_q    <= '0;
      attr_q  <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (acc) begin
        off_q <= req_va[BLK_SH-1:0];
        wr_q  <= req_write;
      end
      if (addr_ld) addr_q <= addr_d;
      if (done_d) begin
        code_q <= code_d;
        lvl_q  <= lvl_d;
        pa_q   <= pa_d;
        attr_q <= attr_d;
      end
    end
  end

  assign done       = done_q;
  assign done_fault = code_q;
  assign done_level = lvl_q;
  assign done_pa    = pa_q;
  assign done_attr  = attr_q;

  // R1: non-canonical request faults next cycle without a read
  a_r1_noncanon_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !canon_ok) |=> (done && done_fault == 2'd1 && !mem_req_valid));

  // R10: read request held steady until taken
  a_r10_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R10: a result follows a response or an accepted request
  a_r10_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(mem_rsp_valid) || $past(req_valid && req_ready)));

  // R9: permission faults only for writes
  a_r9_perm_write_only: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_fault == 2'd3) |-> wr_q);

  // R11: no request accepted while a read is pending
  a_r11_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);
endmodule

// File: tb/ttw_walker_tb_top.sv
module ttw_walker_tb_top;
  localparam logic [47:0] BLO = 48'h0000_1234_0000;
  localparam logic [47:0] BHI = 48'h0000_ABCD_0000;

  typedef struct packed {
    logic [63:0] va;
    logic        wr;
    logic        tg;
    logic [63:0] l2;
    logic [63:0] l3;
    logic [1:0]  code;
    logic [1:0]  lvl;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{64'h0000_0155_5432_1ABC, 1'b0, 1'b0, 64'h1234_8000_6000_0F05, 64'h0, 2'd0, 2'd2},
    '{64'hFFFF_FD23_4567_0123, 1'b0, 1'b0, 64'h0000_0000_2000_0005, 64'h0, 2'd0, 2'd2},
    '{64'h0000_0012_3456_789A, 1'b0, 1'b0, 64'h0000_0000_0055_0003, 64'hBEEF_0777_8889_0083, 2'd0, 2'd3},
    '{64'h0000_0012_3456_789A, 1'b1, 1'b0, 64'h0000_0000_0055_0003, 64'hBEEF_0777_8889_0083, 2'd3, 2'd3},
    '{64'h0000_0012_3456_789A, 1'b1, 1'b0, 64'h0000_0000_6000_0081, 64'h0, 2'd3, 2'd2},
    '{64'h0000_0012_3456_789A, 1'b0, 1'b0, 64'h0000_0000_6000_0081, 64'h0, 2'd0, 2'd2},
    '{64'h0000_0012_3456_789A, 1'b0, 1'b0, 64'h0000_0000_6000_0002, 64'h0, 2'd2, 2'd2},
    '{64'h0000_0012_3456_789A, 1'b0, 1'b0, 64'h0000_0000_0055_0003, 64'h0000_0777_8889_0002, 2'd2, 2'd3},
    '{64'h0000_0012_3456_789A, 1'b0, 1'b0, 64'h0000_0000_0055_0003, 64'h0000_0777_8889_0001, 2'd2, 2'd3},
    '{64'h0000_0400_0000_0000, 1'b0, 1'b0, 64'h0, 64'h0, 2'd1, 2'd0},
    '{64'hA500_0012_3456_789A, 1'b0, 1'b1, 64'h0000_0000_4000_0005, 64'h0, 2'd0, 2'd2},
    '{64'h5AFF_FC12_3456_789A, 1'b0, 1'b1, 64'h0000_0000_0077_0003, 64'h0000_0555_0000_0003, 2'd0, 2'd3},
    '{64'h5AFF_FC12_3456_789A, 1'b0, 1'b0, 64'h0, 64'h0, 2'd1, 2'd0},
    '{64'h0000_0012_3456_789A, 1'b1, 1'b0, 64'h0000_0000_0055_0083, 64'h0, 2'd3, 2'd2},
    '{64'h0000_8000_0000_0000, 1'b0, 1'b1, 64'h0, 64'h0, 2'd1, 2'd0},
    '{64'h0000_03FF_E000_0000, 1'b0, 1'b0, 64'h0000_FFFF_E000_0005, 64'h0, 2'd0, 2'd2}
  };

  logic clk, rst_n;
  logic req_valid, req_ready, req_write, tag_en;
  logic [63:0] req_va;
  logic mem_req_valid, mem_req_ready, mem_rsp_valid;
  logic [47:0] mem_req_addr;
  logic [63:0] mem_rsp_data;
  logic done;
  logic [1:0] done_fault, done_level;
  logic [47:0] done_pa;
  logic [29:0] done_attr;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  ttw_walker dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .req_write(req_write), .tag_en(tag_en),
    .base_lo(BLO), .base_hi(BHI),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done(done), .done_fault(done_fault),
    .done_level(done_level), .done_pa(done_pa), .done_attr(done_attr)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  function automatic logic [47:0] l2addr(input logic [63:0] va, input logic tg);
    logic up;
    up = tg ? va[55] : va[63];
    return (up ? BHI : BLO) + (48'(va[41:29]) << 3);
  endfunction

  function automatic logic [47:0] l3addr(input logic [63:0] va, input logic [63:0] d2);
    return {d2[47:16], 16'h0} + (48'(va[28:16]) << 3);
  endfunction

  function automatic logic [29:0] attr_of(input logic [63:0] d);
    return {d[63:48], d[15:2]};
  endfunction

  // serve one outstanding read after checking hold behaviour (R10)
  task automatic serve(input logic [63:0] data);
    logic [47:0] a0;
    a0 = mem_req_addr;
    @(negedge clk);
    chk(mem_req_valid && mem_req_addr == a0, "R10 request held", {15'b0, mem_req_valid, mem_req_addr}, {15'b0, 1'b1, a0});
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    mem_rsp_data  = data;
    mem_rsp_valid = 1'b1;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
  endtask

  task automatic run_vec(input vec_t v);
    int reads, exp_reads;
    bit seen;
    logic [47:0] ea, epa;
    logic [63:0] fd;
    @(negedge clk);
    req_va = v.va; req_write = v.wr; tag_en = v.tg; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    reads = 0; seen = 0;
    if (v.code == 2'd1) exp_reads = 0;
    else if (v.l2[0] && v.l2[1] && !(v.code == 2'd3 && v.lvl == 2'd2)) exp_reads = 2;
    else exp_reads = 1;
    for (int c = 0; c < 60 && !seen; c++) begin
      if (done) begin
        seen = 1;
        chk(reads == exp_reads, "R10 read count", 64'(reads), 64'(exp_reads));
        chk(done_fault == v.code, "R1 R8 R9 fault code", 64'(done_fault), 64'(v.code));
        chk(done_level == v.lvl, "R8 R9 fault level", 64'(done_level), 64'(v.lvl));
        if (v.code == 2'd0) begin
          fd  = (v.lvl == 2'd3) ? v.l3 : v.l2;
          epa = (v.lvl == 2'd3) ? {v.l3[47:16], v.va[15:0]} : {v.l2[47:29], v.va[28:0]};
          chk(done_pa == epa, "R5 R7 physical address", 64'(done_pa), 64'(epa));
          chk(done_attr == attr_of(fd), "R12 attributes", 64'(done_attr), 64'(attr_of(fd)));
        end else begin
          chk(done_pa == 48'h0 && done_attr == 30'h0, "R12 zero on fault", 64'(done_pa), 64'h0);
        end
        @(negedge clk);
        chk(!done, "R10 done one cycle", 64'(done), 64'h0);
      end else if (mem_req_valid) begin
        if (reads == 0) begin
          ea = l2addr(v.va, v.tg);
          chk(mem_req_addr == ea, "R2 R3 R4 level-2 address", 64'(mem_req_addr), 64'(ea));
          serve(v.l2);
        end else begin
          ea = l3addr(v.va, v.l2);
          chk(mem_req_addr == ea, "R6 level-3 address", 64'(mem_req_addr), 64'(ea));
          serve(v.l3);
        end
        reads++;
      end else begin
        @(negedge clk);
      end
    end
    if (!seen) chk(1'b0, "R10 result pulse missing", 64'h0, 64'h1);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_va = '0; req_write = 1'b0; tag_en = 1'b0;
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !mem_req_valid && req_ready, "R11 reset state",
        {61'b0, done, mem_req_valid, req_ready}, 64'h1);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R11: request while busy is ignored
    @(negedge clk);
    req_va = VECS[0].va; req_write = 1'b0; tag_en = 1'b0; req_valid = 1'b1;
    @(negedge clk);
    req_va = 64'h0000_0400_0000_0000;
    chk(!req_ready && mem_req_valid, "R11 busy not ready", 64'(req_ready), 64'h0);
    @(negedge clk);
    chk(!done, "R11 busy request ignored", 64'(done), 64'h0);
    req_valid = 1'b0;
    serve(VECS[0].l2);
    chk(done && done_fault == 2'd0 && done_pa == {VECS[0].l2[47:29], VECS[0].va[28:0]},
        "R11 original walk result", 64'(done_pa), 64'({VECS[0].l2[47:29], VECS[0].va[28:0]}));
    @(negedge clk);
    chk(!done && req_ready, "R11 no second result", 64'(done), 64'h0);

    // result pulse and next acceptance in the same cycle
    req_va = 64'h0000_0400_0000_0000; req_valid = 1'b1;
    @(negedge clk);
    chk(done && done_fault == 2'd1 && req_ready, "R1 fault with ready", 64'(done_fault), 64'h1);
    req_va = VECS[1].va;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!done && mem_req_valid && mem_req_addr == l2addr(VECS[1].va, 1'b0),
        "R2 overlapped accept", 64'(mem_req_addr), 64'(l2addr(VECS[1].va, 1'b0)));
    serve(VECS[1].l2);
    chk(done && done_fault == 2'd0 && done_pa == {VECS[1].l2[47:29], VECS[1].va[28:0]},
        "R5 overlapped result", 64'(done_pa), 64'({VECS[1].l2[47:29], VECS[1].va[28:0]}));
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule